// File: doc/BRIEF.md
# Token-Chain Analog Readout Sequencer

This controller drives the readout of one or more cascaded charge front-end chips. Each chip holds its shaped channel voltages on track-and-hold cells and puts one channel at a time on a shared analog line. The channel that drives the line is chosen by a single 1 that walks through an on-chip shift register. On a trigger the sequencer waits a programmable number of system clocks, so that the hold command lands on the shaper peak. It then clears the token register, injects one token, and steps it through all channels of all chips. Once per channel it pulses an ADC sample strobe, together with the channel number.

The token register of the chips runs on a slow clock made here. Each readout period lasts `PERIOD` system cycles, and the token clock is high for the first half of the period. The strobe is placed a programmable number of settling cycles into each period. The last stage of the final chip reports when the token reaches the end of the chain. The sequencer checks that this output is high only in the final period, and keeps a sticky error flag when it is not. Triggers that come in while a readout is running are not acted on; they are counted instead.

All outputs are registered, and reset is synchronous and active high. `TOTAL` = 18 × `N_CHIPS` is the number of channels read in one pass.

Top module: `rdo_token_sequencer`

## Requirements
- R1: After reset hold_o, tok_in_o, tok_clk_o, adc_strobe_o, done_o and seq_err_o are 0, adc_chan_o and drop_cnt_o are 0, and tok_rst_o is 1.
- R2: When trig_i is sampled high while the sequencer is idle, the value D on delay_cfg_i is captured at that edge. hold_o then goes high at the (D+2)-th rising edge after that sampling edge.
- R3: tok_rst_o is high at all times, except from the cycle after hold_o rises up to and including the last cycle of the last readout period.
- R4: tok_in_o is high for exactly two cycles per readout: the first cycle with tok_rst_o low, and the next cycle, which is the first cycle with tok_clk_o high. Only one rising edge of tok_clk_o therefore sees it high.
- R5: Starting in the cycle after tok_in_o rises, tok_clk_o runs for TOTAL periods of PERIOD cycles each. It is high in the first PERIOD/2 cycles of each period.
- R6: In period c (0 to TOTAL-1), adc_strobe_o pulses for one cycle at offset S from the cycle in which tok_clk_o rose (S = 0 means that same cycle). adc_chan_o equals c for the whole period and is 0 outside readout periods.
- R7: hold_o stays high from its rise through the last readout period. It falls in the single cycle in which done_o is high, and tok_rst_o is high in that cycle. A trigger sampled while done_o is high starts a new readout.
- R8: last_stage_i is sampled at the edge that ends the second-to-last cycle of each period. It must be 1 in the final period and 0 in every other period. A mismatch sets seq_err_o from the next cycle, and seq_err_o stays set until reset.
- R9: After an accepted trigger, any trig_i sampled high up to and including the edge at which done_o rises is ignored. Each such trigger adds one to drop_cnt_o in the next cycle, and the count saturates at all ones.
- R10: The settle value S (settle_cfg_i) is captured at the accepting edge. Changes to delay_cfg_i or settle_cfg_i during a readout have no effect on that readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Readout trigger |
| delay_cfg_i | input | DLY_W | Trigger-to-hold delay in system clocks |
| settle_cfg_i | input | $clog2(PERIOD) | Strobe offset inside each readout period |
| last_stage_i | input | 1 | Last-stage output of the final chip in the chain |
| hold_o | output | 1 | Hold command to all track-and-hold cells |
| tok_clk_o | output | 1 | Token shift-register clock |
| tok_in_o | output | 1 | Token injected into the first chip |
| tok_rst_o | output | 1 | Clear of the token shift register |
| adc_strobe_o | output | 1 | One-cycle ADC sample strobe |
| adc_chan_o | output | $clog2(TOTAL) | Index of the channel being sampled |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| seq_err_o | output | 1 | Sticky token-chain integrity error |
| drop_cnt_o | output | DROP_W | Saturating count of ignored triggers |

## Verification
A wrong FSM state or slot counter shows up within one system cycle on the registered token, hold and strobe outputs, because every output is a decode of that state. A token clock that is off by one period, or a doubled token, is caught by a bench model of the front-end chain. The chain's last stage then disagrees with the expected period at the next check point, and seq_err_o rises within one readout period. A miscounted delay or settle capture shifts hold_o or adc_strobe_o by whole cycles, and the cycle-by-cycle comparison catches it at once.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
  localparam int CH_PER_CHIP = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CLR,
    ST_LOAD,
    ST_SHIFT,
    ST_DONE
  } rdo_state_e;
endpackage

// File: rtl/rdo_delay_timer.sv
module rdo_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2: the delay counts down by one per clock until it expires
  a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rdo_slot_counter.sv
module rdo_slot_counter #(
  parameter int PERIOD = 8,
  parameter int TOTAL  = 36,
  localparam int PH_W  = $clog2(PERIOD),
  localparam int CH_W  = $clog2(TOTAL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            run,
  output logic [PH_W-1:0] phase_o,
  output logic [CH_W-1:0] chan_o,
  output logic            slot_end_o,
  output logic            last_slot_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase_o <= '0;
      chan_o  <= '0;
    end else if (run) begin
      if (phase_o == PH_LAST) begin
        phase_o <= '0;
        if (chan_o != CH_LAST) chan_o <= chan_o + 1'b1;
      end else begin
        phase_o <= phase_o + 1'b1;
      end
    end
  end

  assign slot_end_o  = (phase_o == PH_LAST);
  assign last_slot_o = (chan_o == CH_LAST);

  // R5: a finished period moves the channel index on by exactly one
  a_r5_chan_advance: assert property (@(posedge clk) disable iff (rst)
    (run && !start && slot_end_o && !last_slot_o) |=> (chan_o == $past(chan_o) + 1'b1));
endmodule

// File: rtl/rdo_chain_monitor.sv
module rdo_chain_monitor (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic expect_hi,
  input  logic last_stage_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst)                                        err_q <= 1'b0;
    else if (sample_en && (last_stage_i != expect_hi)) err_q <= 1'b1;
  end

  assign err_o = err_q;

  // R8: the error flag never clears without reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R8: the flag only rises after a check point
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(sample_en));
endmodule

// File: rtl/rdo_token_sequencer.sv
module rdo_token_sequencer #(
  parameter int N_CHIPS = 2,
  parameter int PERIOD  = 8,
  parameter int DLY_W   = 8,
  parameter int DROP_W  = 8,
  localparam int TOTAL  = rdo_seq_pkg::CH_PER_CHIP * N_CHIPS,
  localparam int CH_W   = $clog2(TOTAL),
  localparam int PH_W   = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [DLY_W-1:0]  delay_cfg_i,
  input  logic [PH_W-1:0]   settle_cfg_i,
  input  logic              last_stage_i,
  output logic              hold_o,
  output logic              tok_clk_o,
  output logic              tok_in_o,
  output logic              tok_rst_o,
  output logic              adc_strobe_o,
  output logic [CH_W-1:0]   adc_chan_o,
  output logic              done_o,
  output logic              seq_err_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  import rdo_seq_pkg::*;

  localparam logic [PH_W-1:0] PH_HALF = PH_W'(PERIOD / 2);

  rdo_state_e        st_q, st_d;
  logic [PH_W-1:0]   settle_q;
  logic [PH_W-1:0]   phase;
  logic [CH_W-1:0]   chan;
  logic              slot_end, last_slot, tmr_expired, accept;
  logic [DROP_W-1:0] drop_q;

  assign accept = trig_i && (st_q == ST_IDLE);

  rdo_delay_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (delay_cfg_i),
    .expired  (tmr_expired)
  );

  rdo_slot_counter #(.PERIOD(PERIOD), .TOTAL(TOTAL)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .start       (st_q == ST_LOAD),
    .run         (st_q == ST_SHIFT),
    .phase_o     (phase),
    .chan_o      (chan),
    .slot_end_o  (slot_end),
    .last_slot_o (last_slot)
  );

  rdo_chain_monitor u_mon (
    .clk          (clk),
    .rst          (rst),
    .sample_en    ((st_q == ST_SHIFT) && slot_end),
    .expect_hi    (last_slot),
    .last_stage_i (last_stage_i),
    .err_o        (seq_err_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (trig_i) st_d = ST_WAIT;
      ST_WAIT:  if (tmr_expired) st_d = ST_CLR;
      ST_CLR:   st_d = ST_LOAD;
      ST_LOAD:  st_d = ST_SHIFT;
      ST_SHIFT: if (slot_end && last_slot) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      settle_q <= '0;
      drop_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) settle_q <= settle_cfg_i;
      if (trig_i && (st_q != ST_IDLE) && (drop_q != '1)) drop_q <= drop_q + 1'b1;
    end
  end

  // registered decode of the current state
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o       <= 1'b0;
      tok_rst_o    <= 1'b1;
      tok_in_o     <= 1'b0;
      tok_clk_o    <= 1'b0;
      adc_strobe_o <= 1'b0;
      adc_chan_o   <= '0;
      done_o       <= 1'b0;
    end else begin
      hold_o       <= (st_q == ST_CLR) || (st_q == ST_LOAD) || (st_q == ST_SHIFT);
      tok_rst_o    <= !((st_q == ST_LOAD) || (st_q == ST_SHIFT));
      tok_in_o     <= (st_q == ST_LOAD) ||
                      ((st_q == ST_SHIFT) && (phase == '0) && (chan == '0));
      tok_clk_o    <= (st_q == ST_SHIFT) && (phase < PH_HALF);
      adc_strobe_o <= (st_q == ST_SHIFT) && (phase == settle_q);
      adc_chan_o   <= (st_q == ST_SHIFT) ? chan : '0;
      done_o       <= (st_q == ST_DONE);
    end
  end

  assign drop_cnt_o = drop_q;

  // R4: the token is gone right after the clock edge that captured it
  a_r4_single_token: assert property (@(posedge clk) disable iff (rst)
    (tok_in_o && tok_clk_o) |=> !tok_in_o);
  // R7: the token clock only runs while values are held
  a_r7_clk_under_hold: assert property (@(posedge clk) disable iff (rst)
    tok_clk_o |-> hold_o);
  // R7: the done pulse releases hold and clears the token register
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!hold_o && tok_rst_o));
  // R6: strobes only appear inside a readout
  a_r6_strobe_in_readout: assert property (@(posedge clk) disable iff (rst)
    adc_strobe_o |-> (hold_o && !tok_rst_o));
  // R9: the dropped-trigger count never goes down
  a_r9_drop_no_decrease: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));
endmodule

// File: tb/rdo_token_sequencer_tb_top.sv
module rdo_token_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CHIPS    = 2;
  localparam int PER        = 8;
  localparam int DLY_W      = 8;
  localparam int DROP_W     = 8;
  localparam int TOTAL      = 18 * N_CHIPS;
  localparam int CH_W       = $clog2(TOTAL);
  localparam int PH_W       = $clog2(PER);
  localparam int DROP_MAX   = (1 << DROP_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_i = 1'b0;
  logic [DLY_W-1:0] delay_cfg_i = '0;
  logic [PH_W-1:0]  settle_cfg_i = '0;
  logic last_stage_i;
  logic hold_o, tok_clk_o, tok_in_o, tok_rst_o, adc_strobe_o, done_o, seq_err_o;
  logic [CH_W-1:0]   adc_chan_o;
  logic [DROP_W-1:0] drop_cnt_o;

  int n_checks = 0;
  int n_errors = 0;
  int fault = 0;  // 0 normal, 1 last stage stuck low, 2 stuck high

  always #(CLK_PERIOD / 2) clk = ~clk;

  rdo_token_sequencer #(.N_CHIPS(N_CHIPS), .PERIOD(PER), .DLY_W(DLY_W), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig_i), .delay_cfg_i(delay_cfg_i),
    .settle_cfg_i(settle_cfg_i), .last_stage_i(last_stage_i), .hold_o(hold_o),
    .tok_clk_o(tok_clk_o), .tok_in_o(tok_in_o), .tok_rst_o(tok_rst_o),
    .adc_strobe_o(adc_strobe_o), .adc_chan_o(adc_chan_o), .done_o(done_o),
    .seq_err_o(seq_err_o), .drop_cnt_o(drop_cnt_o)
  );

  // behavioural front-end chain: one token register across all chips
  logic [TOTAL-1:0] chain = '0;
  always @(posedge tok_clk_o or posedge tok_rst_o) begin
    if (tok_rst_o) chain <= '0;
    else           chain <= {chain[TOTAL-2:0], tok_in_o};
  end
  assign last_stage_i = (fault == 1) ? 1'b0 : (fault == 2) ? 1'b1 : chain[TOTAL-1];

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model: active flag and cycle index since the accepting edge
  int  m_act = 0, m_k = 0, m_d = 0, m_s = 0, m_drops = 0, m_err = 0;
  int  endk, mj, mc, mp, seen;
  bit  started = 0;
  int  e_hold = 0, e_trst = 1, e_tin = 0, e_tclk = 0, e_stb = 0, e_chan = 0, e_done = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_act = 0; m_k = 0; m_drops = 0; m_err = 0;
      e_hold = 0; e_trst = 1; e_tin = 0; e_tclk = 0; e_stb = 0; e_chan = 0; e_done = 0;
    end else begin
      endk = m_d + 3 + TOTAL * PER;
      e_hold = 0; e_trst = 1; e_tin = 0; e_tclk = 0; e_stb = 0; e_chan = 0; e_done = 0;
      if (m_act != 0) begin
        if (m_k == m_d + 1) begin
          e_hold = 1;
        end else if (m_k == m_d + 2) begin
          e_hold = 1; e_trst = 0; e_tin = 1;
        end else if (m_k >= m_d + 3 && m_k < endk) begin
          mj = m_k - (m_d + 3); mc = mj / PER; mp = mj % PER;
          e_hold = 1; e_trst = 0;
          e_tin  = (mj == 0) ? 1 : 0;
          e_tclk = (mp < PER / 2) ? 1 : 0;
          e_stb  = (mp == m_s) ? 1 : 0;
          e_chan = mc;
          if (mp == PER - 1) begin
            seen = (fault == 1) ? 0 : (fault == 2) ? 1 : ((mc == TOTAL - 1) ? 1 : 0);
            if (seen != ((mc == TOTAL - 1) ? 1 : 0)) m_err = 1;
          end
        end else if (m_k == endk) begin
          e_done = 1;
        end
        if (trig_i && m_drops < DROP_MAX) m_drops++;
        m_k++;
        if (m_k > endk) m_act = 0;
      end else if (trig_i) begin
        m_act = 1; m_k = 0; m_d = int'(delay_cfg_i); m_s = int'(settle_cfg_i);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R2/R7", "hold_o",       hold_o,       e_hold);
      check("R3",    "tok_rst_o",    tok_rst_o,    e_trst);
      check("R4",    "tok_in_o",     tok_in_o,     e_tin);
      check("R5",    "tok_clk_o",    tok_clk_o,    e_tclk);
      check("R6/R10","adc_strobe_o", adc_strobe_o, e_stb);
      check("R6",    "adc_chan_o",   adc_chan_o,   e_chan);
      check("R7",    "done_o",       done_o,       e_done);
      check("R8",    "seq_err_o",    seq_err_o,    m_err);
      check("R9",    "drop_cnt_o",   drop_cnt_o,   m_drops);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; trig_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_one(input int d, input int s);
    int  n_stb = 0;
    int  n_rise = 0;
    logic prev = 1'b0;
    @(negedge clk); delay_cfg_i = DLY_W'(d); settle_cfg_i = PH_W'(s); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    while (!done_o) begin
      @(negedge clk);
      if (adc_strobe_o) n_stb++;
      if (tok_clk_o && !prev) n_rise++;
      prev = tok_clk_o;
    end
    check("R6", "strobes per readout", n_stb, TOTAL);
    check("R5", "token clock rises per readout", n_rise, TOTAL);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "hold after reset", hold_o, 0);
    check("R1", "token reset after reset", tok_rst_o, 1);
    check("R1", "strobe after reset", adc_strobe_o, 0);
    check("R1", "error after reset", seq_err_o, 0);
    check("R1", "drops after reset", drop_cnt_o, 0);

    run_one(3, 2);
    run_one(0, 0);
    check("R8", "no error on a healthy chain", seq_err_o, 0);

    // R10 and R9: config changes and triggers during a readout
    @(negedge clk); delay_cfg_i = 8'd20; settle_cfg_i = 3'd7; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    repeat (40) @(negedge clk);
    delay_cfg_i = 8'd5; settle_cfg_i = 3'd1;
    for (int i = 0; i < 3; i++) begin
      trig_i = 1'b1; @(negedge clk); trig_i = 1'b0; @(negedge clk);
    end
    wait_done();
    check("R9", "three triggers dropped", drop_cnt_o, 3);

    // R7: trigger while done_o is high is accepted
    @(negedge clk); delay_cfg_i = 8'd2; settle_cfg_i = 3'd4; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    while (!done_o) @(negedge clk);
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    check("R7", "hold low right after done", hold_o, 0);
    wait_done();

    // R8: last stage stuck low
    do_reset(); fault = 1;
    run_one(1, 3);
    check("R8", "error on missing token", seq_err_o, 1);

    // R8: last stage stuck high
    do_reset(); fault = 2;
    run_one(4, 5);
    check("R8", "error on early token", seq_err_o, 1);

    // R9: saturation with the trigger held high
    do_reset(); fault = 0;
    @(negedge clk); delay_cfg_i = 8'd200; settle_cfg_i = 3'd6; trig_i = 1'b1;
    repeat (700) @(negedge clk);
    trig_i = 1'b0;
    wait_done();
    check("R9", "drop counter saturates", drop_cnt_o, DROP_MAX);
    check("R8", "no error after saturation run", seq_err_o, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule